// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Latch

This block turns a set of active-low interrupt request lines, grouped in banks of 32, into pending bits for a downstream priority arbiter. Each raw request is passed through a two-stage synchronizer. Each line is then treated in one of two ways. A falling-edge line latches a pending bit when its request newly asserts. A low-level line has a pending bit that simply mirrors whether its request is asserted.

The block also holds, for each line, a small configuration word with a priority, a sensitivity select and a fast-path routing select. It holds a per-bank mask and a per-bank software request word. Software can clear pending bits through an AND-style bank write. The arbiter's acknowledgement of a winning line clears that line's pending bit when the line is edge-sensitive. A one-cycle strobe tells the arbiter to re-evaluate whenever any pending bit newly becomes set.

Top module: `edge_lvl_pend_latch`

## Requirements
- R1: During and right after reset, every pending bit is 0, every mask bit is 1, every configuration word reads 0, every software request is 0 and the re-arbitration strobe is low.
- R2: For a falling-edge line (sensitivity bit 0), the pending bit becomes 1 on the third rising clock edge after the active-low request input falls. Holding the request low after the bit was cleared does not set it again; the request must go high and then low again to set it.
- R3: For a low-level line (sensitivity bit 1), the pending bit is 1 while the synchronized request is asserted and becomes 0 three rising edges after the request input returns high.
- R4: A pending-clear write to bank b ANDs that bank's pending bits with the write data: a 0 bit clears the edge-sensitive line's bit, and a 1 bit leaves it unchanged. Other banks are unaffected.
- R5: A pending-clear write has no effect on a level-sensitive line whose request is still asserted.
- R6: An acknowledge of line index k clears the pending bit of k on the next edge if k is edge-sensitive, and leaves it set if k is level-sensitive with its request asserted.
- R7: The configuration word of line k is 7 bits: priority in bits [6:2], sensitivity in bit 1 and fast routing in bit 0. A write stores it, and it reads back in the same layout at index k. The priority and routing also appear on prio_o[k*5 +: 5] and fast_o[k]. Other lines are unchanged.
- R8: A software-request write to bank b replaces that bank's software request word. A 1 bit acts as an asserted request for the line, with no synchronizer delay, and is seen in the pending bit on the second edge after the write. Writing 0 removes the request.
- R9: The re-arbitration strobe is high for exactly the one cycle in which one or more pending bits go from 0 to 1. It stays low while a pending bit simply remains set.
- R10: A mask write to bank b replaces bank b's mask bits (mask_o bits [b*32 +: 32]). A bank index at or above the number of banks changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | 96 | Raw interrupt requests, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_idx_i | input | 7 | Line index for configuration write and readback |
| cfg_wdata_i | input | 7 | Configuration word to write |
| cfg_rdata_o | output | 7 | Configuration word of line cfg_idx_i |
| bank_i | input | 2 | Bank select for pending-clear, software-request and mask writes |
| wdata_i | input | 32 | Bank write data |
| pend_clr_we_i | input | 1 | Pending AND-clear write strobe |
| swi_we_i | input | 1 | Software request word write strobe |
| mask_we_i | input | 1 | Mask word write strobe |
| vec_ack_i | input | 1 | Arbiter acknowledge of a winning line |
| vec_idx_i | input | 7 | Line index being acknowledged |
| pend_o | output | 96 | Pending bits |
| mask_o | output | 96 | Mask bits (1 = masked) |
| fast_o | output | 96 | Fast routing select per line |
| prio_o | output | 480 | Priority per line, 5 bits each |
| retrig_o | output | 1 | One-cycle re-arbitration strobe |

## Verification
The checker assumes that the acknowledge index names an existing line, and it only evaluates the acknowledge property when the index is below the line count. It also assumes that sensitivity is not flipped in the same cycle as the event being judged, because each property compares a pending bit against the previous cycle's sensitivity and effective request. The bench drives every write strobe for exactly one cycle on the falling edge. It keeps acknowledge indices inside the 96 lines and configures each line's sensitivity well before it touches that line's request. This keeps the stimulus inside those assumptions.

// File: rtl/epl_pkg.sv
package epl_pkg;
  localparam int unsigned PRIO_W = 5;
  localparam int unsigned CFG_W  = PRIO_W + 2;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              sens;  // 0 falling edge, 1 low level
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/epl_cfg_regs.sv
module epl_cfg_regs
  import epl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [CFG_W-1:0]            wdata_i,
  output logic [CFG_W-1:0]            rdata_o,
  output logic [NUM_LINES-1:0]        sens_o,
  output logic [NUM_LINES-1:0]        fast_o,
  output logic [NUM_LINES*PRIO_W-1:0] prio_o
);
  line_cfg_t cfg_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= '0;
    end else if (we_i && (int'(idx_i) < NUM_LINES)) begin
      cfg_q[idx_i] <= line_cfg_t'(wdata_i);
    end
  end

  assign rdata_o = (int'(idx_i) < NUM_LINES) ? cfg_q[idx_i] : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_out
    assign sens_o[g]                 = cfg_q[g].sens;
    assign fast_o[g]                 = cfg_q[g].fast;
    assign prio_o[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
  end
endmodule

// File: rtl/epl_pend_core.sv
module epl_pend_core #(
  parameter int unsigned NUM_BANKS  = 3,
  parameter int unsigned BANK_W     = 32,
  parameter int unsigned BANK_IDX_W = 2,
  parameter int unsigned IDX_W      = 7,
  localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  req_i,
  input  logic [NUM_LINES-1:0]  sens_i,
  input  logic                  clr_we_i,
  input  logic [BANK_IDX_W-1:0] bank_i,
  input  logic [BANK_W-1:0]     wdata_i,
  input  logic                  ack_i,
  input  logic [IDX_W-1:0]      ack_idx_i,
  output logic [NUM_LINES-1:0]  pend_o,
  output logic [NUM_LINES-1:0]  req_prev_o,
  output logic                  retrig_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d, req_prev_q;
  logic                 retrig_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam int unsigned LB = g / BANK_W;
    localparam int unsigned LI = g % BANK_W;
    logic clr_hit, ack_hit, rise;
    assign clr_hit = clr_we_i && (bank_i == BANK_IDX_W'(LB)) && !wdata_i[LI];
    assign ack_hit = ack_i && (ack_idx_i == IDX_W'(g));
    assign rise    = req_i[g] && !req_prev_q[g];
    // level lines mirror the request; edge lines latch, new event beats a clear
    assign pend_d[g] = sens_i[g] ? req_i[g]
                                 : (rise || (pend_q[g] && !(clr_hit || ack_hit)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      req_prev_q <= '0;
      retrig_q   <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      req_prev_q <= req_i;
      retrig_q   <= |(pend_d & ~pend_q);
    end
  end

  assign pend_o     = pend_q;
  assign req_prev_o = req_prev_q;
  assign retrig_o   = retrig_q;
endmodule

// File: rtl/edge_lvl_pend_latch.sv
module edge_lvl_pend_latch
  import epl_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_LINES  = NUM_BANKS * BANK_W,
  localparam int unsigned IDX_W      = $clog2(NUM_LINES),
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        req_ni,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_idx_i,
  input  logic [CFG_W-1:0]            cfg_wdata_i,
  output logic [CFG_W-1:0]            cfg_rdata_o,
  input  logic [BANK_IDX_W-1:0]       bank_i,
  input  logic [BANK_W-1:0]           wdata_i,
  input  logic                        pend_clr_we_i,
  input  logic                        swi_we_i,
  input  logic                        mask_we_i,
  input  logic                        vec_ack_i,
  input  logic [IDX_W-1:0]            vec_idx_i,
  output logic [NUM_LINES-1:0]        pend_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        fast_o,
  output logic [NUM_LINES*PRIO_W-1:0] prio_o,
  output logic                        retrig_o
);
  logic [NUM_LINES-1:0] req_sync_n, req_act, req_prev, sens_vec;
  logic [NUM_BANKS-1:0][BANK_W-1:0] swi_q, mask_q;

  epl_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(req_ni), .q_o(req_sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q  <= '0;
      mask_q <= '1;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (swi_we_i  && bank_i == BANK_IDX_W'(b)) swi_q[b]  <= wdata_i;
        if (mask_we_i && bank_i == BANK_IDX_W'(b)) mask_q[b] <= wdata_i;
      end
    end
  end

  assign req_act = ~req_sync_n | swi_q;
  assign mask_o  = mask_q;

  epl_cfg_regs #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .sens_o(sens_vec), .fast_o(fast_o), .prio_o(prio_o)
  );

  epl_pend_core #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_IDX_W(BANK_IDX_W), .IDX_W(IDX_W)
  ) u_pend (
    .clk_i, .rst_ni,
    .req_i(req_act), .sens_i(sens_vec),
    .clr_we_i(pend_clr_we_i), .bank_i(bank_i), .wdata_i(wdata_i),
    .ack_i(vec_ack_i), .ack_idx_i(vec_idx_i),
    .pend_o(pend_o), .req_prev_o(req_prev), .retrig_o(retrig_o)
  );
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned PRIO_W    = 5
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        vec_ack_i,
  input logic [IDX_W-1:0]            vec_idx_i,
  input logic                        mask_we_i,
  input logic                        cfg_we_i,
  input logic [NUM_LINES-1:0]        pend_o,
  input logic [NUM_LINES-1:0]        mask_o,
  input logic [NUM_LINES-1:0]        fast_o,
  input logic [NUM_LINES*PRIO_W-1:0] prio_o,
  input logic                        retrig_o,
  input logic [NUM_LINES-1:0]        req_act,
  input logic [NUM_LINES-1:0]        req_prev,
  input logic [NUM_LINES-1:0]        sens_vec
);
  p_edge_needs_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~$past(pend_o) & ~$past(sens_vec) & ~$past(req_act & ~req_prev)) == '0);

  p_level_mirrors_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o ^ $past(req_act)) & $past(sens_vec)) == '0);

  p_ack_clears_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && (int'(vec_idx_i) < NUM_LINES) && !sens_vec[vec_idx_i] &&
     !(req_act[vec_idx_i] && !req_prev[vec_idx_i]))
    |=> !pend_o[$past(vec_idx_i)]);

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(fast_o) && $stable(prio_o) && $stable(sens_vec)));

  p_retrig_new_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrig_o |-> ((pend_o & ~$past(pend_o)) != '0));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o));
endmodule

bind edge_lvl_pend_latch epl_checker #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .PRIO_W(epl_pkg::PRIO_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vec_ack_i(vec_ack_i), .vec_idx_i(vec_idx_i),
  .mask_we_i(mask_we_i), .cfg_we_i(cfg_we_i), .pend_o(pend_o), .mask_o(mask_o),
  .fast_o(fast_o), .prio_o(prio_o), .retrig_o(retrig_o),
  .req_act(req_act), .req_prev(req_prev), .sens_vec(sens_vec)
);

// File: tb/edge_lvl_pend_latch_bench.sv
module edge_lvl_pend_latch_bench;
  localparam int N = 96;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_ni = '1;
  logic         cfg_we_i = 1'b0;
  logic [6:0]   cfg_idx_i = '0;
  logic [6:0]   cfg_wdata_i = '0;
  logic [6:0]   cfg_rdata_o;
  logic [1:0]   bank_i = '0;
  logic [31:0]  wdata_i = '0;
  logic         pend_clr_we_i = 1'b0, swi_we_i = 1'b0, mask_we_i = 1'b0;
  logic         vec_ack_i = 1'b0;
  logic [6:0]   vec_idx_i = '0;
  logic [N-1:0] pend_o, mask_o, fast_o;
  logic [N*5-1:0] prio_o;
  logic         retrig_o;

  int checks = 0, fails = 0;

  always #10ns clk_i = ~clk_i;

  edge_lvl_pend_latch u_edge_lvl_pend_latch (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // kind: 0 pending clear, 1 software request, 2 mask
  task automatic bank_wr(input int kind, input logic [1:0] b, input logic [31:0] d);
    bank_i = b; wdata_i = d;
    pend_clr_we_i = (kind == 0); swi_we_i = (kind == 1); mask_we_i = (kind == 2);
    tick(1);
    pend_clr_we_i = 1'b0; swi_we_i = 1'b0; mask_we_i = 1'b0;
  endtask

  task automatic cfg_wr(input int idx, input logic [6:0] d);
    cfg_idx_i = 7'(idx); cfg_wdata_i = d; cfg_we_i = 1'b1;
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic ack(input int idx);
    vec_idx_i = 7'(idx); vec_ack_i = 1'b1;
    tick(1);
    vec_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 pend in reset", 32'(|pend_o), 0);
    rst_ni = 1'b1;
    tick(2);
    check("R1 pend", 32'(|pend_o), 0);
    check("R1 mask", 32'(&mask_o), 1);
    check("R1 retrig", 32'(retrig_o), 0);
    cfg_idx_i = 7'd95;
    #1ns check("R1 cfg 95", 32'(cfg_rdata_o), 0);
    cfg_idx_i = 7'd0;
    #1ns check("R1 cfg 0", 32'(cfg_rdata_o), 0);
  endtask

  task automatic t_cfg();
    cfg_wr(70, 7'h7D);
    cfg_wr(40, 7'h02);
    cfg_wr(71, 7'h02);
    cfg_idx_i = 7'd70;
    #1ns check("R7 readback 70", 32'(cfg_rdata_o), 32'h7D);
    check("R7 prio 70", 32'(prio_o[70*5 +: 5]), 31);
    check("R7 fast 70", 32'(fast_o[70]), 1);
    cfg_idx_i = 7'd69;
    #1ns check("R7 neighbour 69", 32'(cfg_rdata_o), 0);
    cfg_idx_i = 7'd40;
    #1ns check("R7 readback 40", 32'(cfg_rdata_o), 32'h02);
    check("R7 fast 40", 32'(fast_o[40]), 0);
  endtask

  task automatic t_edge();
    req_ni[5] = 1'b0;
    tick(2);
    check("R2 not yet set", 32'(pend_o[5]), 0);
    tick(1);
    check("R2 set third edge", 32'(pend_o[5]), 1);
    check("R9 strobe", 32'(retrig_o), 1);
    tick(1);
    check("R9 strobe one cycle", 32'(retrig_o), 0);
    bank_wr(0, 2'd0, 32'hFFFF_FFFF);
    check("R4 ones keep", 32'(pend_o[5]), 1);
    bank_wr(0, 2'd1, 32'h0);
    check("R4 other bank", 32'(pend_o[5]), 1);
    bank_wr(0, 2'd0, ~(32'h1 << 5));
    check("R4 zero clears", 32'(pend_o[5]), 0);
    tick(4);
    check("R2 held low no reset", 32'(pend_o[5]), 0);
    req_ni[5] = 1'b1;
    tick(3);
    req_ni[5] = 1'b0;
    tick(3);
    check("R2 new fall", 32'(pend_o[5]), 1);
    ack(5);
    check("R6 ack clears edge", 32'(pend_o[5]), 0);
    req_ni[5] = 1'b1;
    tick(3);
  endtask

  task automatic t_level();
    req_ni[40] = 1'b0;
    tick(3);
    check("R3 level set", 32'(pend_o[40]), 1);
    check("R9 strobe level", 32'(retrig_o), 1);
    tick(2);
    check("R9 no repeat", 32'(retrig_o), 0);
    bank_wr(0, 2'd1, 32'h0);
    check("R5 clear ignored", 32'(pend_o[40]), 1);
    ack(40);
    check("R6 ack ignored level", 32'(pend_o[40]), 1);
    req_ni[40] = 1'b1;
    tick(2);
    check("R3 still set", 32'(pend_o[40]), 1);
    tick(1);
    check("R3 level clears", 32'(pend_o[40]), 0);
  endtask

  task automatic t_swi();
    bank_wr(1, 2'd2, 32'h1 << 6);
    check("R8 not yet", 32'(pend_o[70]), 0);
    tick(1);
    check("R8 edge swi set", 32'(pend_o[70]), 1);
    bank_wr(1, 2'd2, 32'h0);
    tick(1);
    check("R8 edge stays", 32'(pend_o[70]), 1);
    bank_wr(0, 2'd2, ~(32'h1 << 6));
    check("R4 clear swi line", 32'(pend_o[70]), 0);
    bank_wr(1, 2'd2, 32'h1 << 7);
    tick(1);
    check("R8 level swi set", 32'(pend_o[71]), 1);
    bank_wr(1, 2'd2, 32'h0);
    tick(1);
    check("R8 level swi removed", 32'(pend_o[71]), 0);
  endtask

  task automatic t_mask();
    bank_wr(2, 2'd1, 32'h0000_FFFF);
    check("R10 bank1", mask_o[63:32], 32'h0000_FFFF);
    check("R10 bank0", mask_o[31:0], 32'hFFFF_FFFF);
    bank_wr(2, 2'd3, 32'h0);
    check("R10 bad bank b2", mask_o[95:64], 32'hFFFF_FFFF);
    check("R10 bad bank b1", mask_o[63:32], 32'h0000_FFFF);
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_edge();
    t_level();
    t_swi();
    t_mask();
    summary();
  end

  initial begin
    #4ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule